// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

The sequencer accepts coprocessor-style cache maintenance commands, each selected by a 4-bit CRm field and a 3-bit opcode2 field and carrying a 32-bit data word. It carries each command out on a small register-based model of an instruction cache, a data cache and a branch target cache. All three are direct-mapped tables with the same number of lines. Each line holds a tag, a valid bit, a dirty bit and a lock bit.

Whole-cache commands walk every line, one per cycle. A dirty data line that must be cleaned stalls the walk while a writeback request is acknowledged on a simple request/acknowledge port. Single-line commands take a virtual address and act only on a line whose tag matches. Whole-data-cache clean walks stop at a line boundary when an interrupt is pending. Reissuing the same command resumes the walk. A user-mode command is refused with a trap. A fill port loads lines and a probe port reads them, so the model can be preset and observed.

Top module: `cache_maint_seq`

## Requirements
- R1: Whole-cache commands, with opcode2=0: CRm=5 invalidates every instruction line, CRm=6 invalidates every data line, CRm=7 invalidates both caches, CRm=10 cleans every data line, and CRm=14 cleans and invalidates every data line. Each command walks lines 0 to N_LINES-1.
- R2: Single-line commands use opcode2=1: CRm=5 invalidates an instruction line, CRm=6 invalidates a data line, CRm=10 cleans a data line, and CRm=14 cleans and invalidates a data line. The line index is data[5+IDX_W-1:5] and the tag is data[31:5+IDX_W]. The command acts only on a valid line whose tag matches. Bits [4:0] are ignored.
- R3: CRm=5/opc2=0 and CRm=7/opc2=0 also clear every branch target entry as part of the same command. CRm=5/opc2=6 clears every branch target entry and nothing else.
- R4: A single instruction-line invalidate leaves the branch target cache untouched. CRm=5/opc2=7 clears only the branch target entry that matches the address.
- R5: Clean, invalidate and clean-and-invalidate act on matching lines whatever their lock bit is. The lock bit itself is preserved.
- R6: A command accepted with cmd_user_i=1, or with an encoding not listed in R1 to R4, sets trap_o high for the next cycle only. busy_o stays low and no cache line changes.
- R7: Cleaning a valid dirty data line raises wb_req_o with wb_addr_o = {tag, index, 5'b0}. Both stay steady until wb_ack_i. The dirty bit clears on acknowledge, and clean-and-invalidate also clears the valid bit. Invalidate-only commands never write back.
- R8: During CRm=10 or CRm=14 whole walks, if irq_i is high when a line that is not the last one completes, the walk stops after that line. intr_o then goes high and busy_o goes low.
- R9: After an interrupted walk, reissuing the same command resumes at the next line. The final cache state and the set of writebacks equal those of an uninterrupted run. intr_o clears when the next command is accepted.
- R10: busy_o is high from the cycle after a legal command is accepted until its last line completes. A command presented while busy_o is high is dropped.
- R11: dirty_o is high exactly when some data line is valid and dirty.
- R12: After reset, all lines are invalid, and busy_o, trap_o, intr_o, dirty_o and wb_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_user_i | input | 1 | Command issued from user mode |
| cmd_crm_i | input | 4 | CRm selector |
| cmd_opc2_i | input | 3 | Opcode2 selector |
| cmd_data_i | input | 32 | Data word (virtual address or zero) |
| irq_i | input | 1 | Pending interrupt |
| busy_o | output | 1 | Command in progress |
| trap_o | output | 1 | Undefined-instruction trap pulse |
| intr_o | output | 1 | Last whole walk was interrupted |
| dirty_o | output | 1 | Some data line is valid and dirty |
| wb_req_o | output | 1 | Writeback request |
| wb_addr_o | output | 32 | Writeback line address |
| wb_ack_i | input | 1 | Writeback acknowledge |
| fill_en_i | input | 1 | Load a line |
| fill_sel_i | input | 2 | Table to load: 0 instruction, 1 data, 2 branch target |
| fill_va_i | input | 32 | Address of line to load |
| fill_dirty_i | input | 1 | Dirty bit for loaded data line |
| fill_lock_i | input | 1 | Lock bit for loaded line |
| probe_sel_i | input | 2 | Table to probe, same coding as fill_sel_i |
| probe_va_i | input | 32 | Address to probe |
| probe_hit_o | output | 1 | Probed line valid with matching tag |
| probe_dirty_o | output | 1 | Dirty bit of probed line |
| probe_lock_o | output | 1 | Lock bit of probed line |

## Verification
A wrong walk index or a lost resume point shows up as a writeback address set with lines missing or repeated. It appears within a few cycles of the walk ending, because the XOR and count of the acknowledged addresses differ from those of the filled dirty lines. A stuck dirty or valid bit appears on dirty_o or on the next probe as soon as the command drops busy_o. A wrong branch-target coupling appears on the branch-target probe right after the instruction-cache command.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned LINE_OFF = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_LINE, ST_WB} st_e;

  typedef struct packed {
    logic legal;
    logic whole;
    logic tgt_i;
    logic tgt_d;
    logic clean;
    logic inv;
    logic btc_all;
    logic btc_line;
    logic intr_ok;
  } op_attr_t;

  function automatic op_attr_t decode_op(input logic [3:0] crm, input logic [2:0] opc2);
    op_attr_t a;
    a = '0;
    case ({crm, opc2})
      {4'd5, 3'd0}:  begin a.legal = 1'b1; a.whole = 1'b1; a.tgt_i = 1'b1; a.inv = 1'b1; a.btc_all = 1'b1; end
      {4'd6, 3'd0}:  begin a.legal = 1'b1; a.whole = 1'b1; a.tgt_d = 1'b1; a.inv = 1'b1; end
      {4'd7, 3'd0}:  begin a.legal = 1'b1; a.whole = 1'b1; a.tgt_i = 1'b1; a.tgt_d = 1'b1; a.inv = 1'b1; a.btc_all = 1'b1; end
      {4'd10, 3'd0}: begin a.legal = 1'b1; a.whole = 1'b1; a.tgt_d = 1'b1; a.clean = 1'b1; a.intr_ok = 1'b1; end
      {4'd14, 3'd0}: begin a.legal = 1'b1; a.whole = 1'b1; a.tgt_d = 1'b1; a.clean = 1'b1; a.inv = 1'b1; a.intr_ok = 1'b1; end
      {4'd5, 3'd1}:  begin a.legal = 1'b1; a.tgt_i = 1'b1; a.inv = 1'b1; end
      {4'd6, 3'd1}:  begin a.legal = 1'b1; a.tgt_d = 1'b1; a.inv = 1'b1; end
      {4'd10, 3'd1}: begin a.legal = 1'b1; a.tgt_d = 1'b1; a.clean = 1'b1; end
      {4'd14, 3'd1}: begin a.legal = 1'b1; a.tgt_d = 1'b1; a.clean = 1'b1; a.inv = 1'b1; end
      {4'd5, 3'd6}:  begin a.legal = 1'b1; a.btc_all = 1'b1; end
      {4'd5, 3'd7}:  begin a.legal = 1'b1; a.btc_line = 1'b1; end
      default:       a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cms_decode.sv
module cms_decode
  import cms_pkg::*;
(
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  input  logic       user_i,
  output op_attr_t   attr_o,
  output logic       bad_o,
  output logic [6:0] key_o
);
  always_comb begin
    attr_o = decode_op(crm_i, opc2_i);
    // every maintenance command is privileged
    bad_o  = user_i || !attr_o.legal;
    key_o  = {crm_i, opc2_i};
  end
endmodule

// File: rtl/cms_line_array.sv
module cms_line_array #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned TAG_W   = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_dirty_i,
  input  logic             fill_lock_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic             inv_en_i,
  input  logic             cln_en_i,
  input  logic             clr_all_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic [IDX_W-1:0] pr_idx_i,
  output logic             pr_valid_o,
  output logic             pr_dirty_o,
  output logic             pr_lock_o,
  output logic [TAG_W-1:0] pr_tag_o,
  output logic             any_dirty_o
);
  logic [N_LINES-1:0] valid_q, dirty_q, lock_q;
  logic [TAG_W-1:0]   tag_q [N_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      lock_q  <= '0;
      for (int i = 0; i < N_LINES; i++) tag_q[i] <= '0;
    end else if (clr_all_i) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < N_LINES; i++) begin
        if (fill_en_i && fill_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= fill_dirty_i;
          lock_q[i]  <= fill_lock_i;
          tag_q[i]   <= fill_tag_i;
        end
        // lock bit is not consulted by maintenance
        if (op_idx_i == IDX_W'(i)) begin
          if (cln_en_i) dirty_q[i] <= 1'b0;
          if (inv_en_i) begin
            valid_q[i] <= 1'b0;
            dirty_q[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_valid_o  = valid_q[op_idx_i];
  assign rd_dirty_o  = dirty_q[op_idx_i];
  assign rd_tag_o    = tag_q[op_idx_i];
  assign pr_valid_o  = valid_q[pr_idx_i];
  assign pr_dirty_o  = dirty_q[pr_idx_i];
  assign pr_lock_o   = lock_q[pr_idx_i];
  assign pr_tag_o    = tag_q[pr_idx_i];
  assign any_dirty_o = |(valid_q & dirty_q);
endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned TAG_W   = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  op_attr_t         attr_i,
  input  logic             bad_i,
  input  logic [6:0]       key_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [TAG_W-1:0] cmd_tag_i,
  input  logic             irq_i,
  input  logic             wb_ack_i,
  input  logic             d_valid_i,
  input  logic             d_dirty_i,
  input  logic [TAG_W-1:0] d_tag_i,
  input  logic             i_valid_i,
  input  logic [TAG_W-1:0] i_tag_i,
  input  logic             b_valid_i,
  input  logic [TAG_W-1:0] b_tag_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             d_inv_o,
  output logic             d_cln_o,
  output logic             i_inv_o,
  output logic             b_inv_o,
  output logic             b_clr_all_o,
  output logic             busy_o,
  output logic             trap_o,
  output logic             intr_o,
  output logic             wb_req_o,
  output logic [31:0]      wb_addr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LINES - 1);

  st_e              st_q;
  op_attr_t         attr_q;
  logic [6:0]       key_q, saved_key_q;
  logic [IDX_W-1:0] idx_q, saved_idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             intr_q, trap_q;

  logic acc, start, resume, fin, go_wb, last;
  logic hit_d, hit_i, hit_b;

  always_comb begin
    acc    = cmd_valid_i && (st_q == ST_IDLE);
    start  = acc && !bad_i;
    resume = intr_q && (saved_key_q == key_i);
    last   = (idx_q == LAST_IDX);
    hit_d  = d_valid_i && (attr_q.whole || d_tag_i == tag_q);
    hit_i  = i_valid_i && (attr_q.whole || i_tag_i == tag_q);
    hit_b  = b_valid_i && (b_tag_i == tag_q);
    fin = 1'b0; go_wb = 1'b0;
    d_inv_o = 1'b0; d_cln_o = 1'b0; i_inv_o = 1'b0; b_inv_o = 1'b0;
    if (st_q == ST_WALK || st_q == ST_LINE) begin
      if (attr_q.tgt_d && attr_q.clean && hit_d && d_dirty_i) begin
        go_wb = 1'b1;
      end else begin
        fin     = 1'b1;
        d_inv_o = attr_q.tgt_d && attr_q.inv && hit_d;
        i_inv_o = attr_q.tgt_i && attr_q.inv && hit_i;
        b_inv_o = attr_q.btc_line && hit_b;
      end
    end else if (st_q == ST_WB && wb_ack_i) begin
      fin     = 1'b1;
      d_cln_o = 1'b1;
      d_inv_o = attr_q.inv;
    end
    b_clr_all_o = start && attr_i.btc_all;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      attr_q      <= '0;
      key_q       <= '0;
      saved_key_q <= '0;
      idx_q       <= '0;
      saved_idx_q <= '0;
      tag_q       <= '0;
      intr_q      <= 1'b0;
      trap_q      <= 1'b0;
    end else begin
      trap_q <= acc && bad_i;
      if (acc) begin
        intr_q <= 1'b0;
        if (!bad_i) begin
          attr_q <= attr_i;
          key_q  <= key_i;
          tag_q  <= cmd_tag_i;
          if (attr_i.whole) begin
            idx_q <= resume ? saved_idx_q : '0;
            st_q  <= ST_WALK;
          end else begin
            idx_q <= cmd_idx_i;
            st_q  <= ST_LINE;
          end
        end
      end else if (go_wb) begin
        st_q <= ST_WB;
      end else if (fin) begin
        if (!attr_q.whole || last) begin
          st_q <= ST_IDLE;
        end else if (attr_q.intr_ok && irq_i) begin
          st_q        <= ST_IDLE;
          intr_q      <= 1'b1;
          saved_idx_q <= idx_q + 1'b1;
          saved_key_q <= key_q;
        end else begin
          idx_q <= idx_q + 1'b1;
          st_q  <= ST_WALK;
        end
      end
    end
  end

  assign idx_o     = idx_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign trap_o    = trap_q;
  assign intr_o    = intr_q;
  assign wb_req_o  = (st_q == ST_WB);
  assign wb_addr_o = {d_tag_i, idx_q, 5'b0};
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cms_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic        cmd_user_i,
  input  logic [3:0]  cmd_crm_i,
  input  logic [2:0]  cmd_opc2_i,
  input  logic [31:0] cmd_data_i,
  input  logic        irq_i,
  output logic        busy_o,
  output logic        trap_o,
  output logic        intr_o,
  output logic        dirty_o,
  output logic        wb_req_o,
  output logic [31:0] wb_addr_o,
  input  logic        wb_ack_i,
  input  logic        fill_en_i,
  input  logic [1:0]  fill_sel_i,
  input  logic [31:0] fill_va_i,
  input  logic        fill_dirty_i,
  input  logic        fill_lock_i,
  input  logic [1:0]  probe_sel_i,
  input  logic [31:0] probe_va_i,
  output logic        probe_hit_o,
  output logic        probe_dirty_o,
  output logic        probe_lock_o
);
  localparam int unsigned IDX_W = $clog2(N_LINES);
  localparam int unsigned TAG_W = ADDR_W - LINE_OFF - IDX_W;
  localparam int unsigned N_TBL = 3;

  op_attr_t   attr;
  logic       bad;
  logic [6:0] key;
  logic [IDX_W-1:0] op_idx;

  logic [N_TBL-1:0] t_fill, t_inv, t_cln, t_clr;
  logic [N_TBL-1:0] t_rd_valid, t_rd_dirty, t_pr_valid, t_pr_dirty, t_pr_lock, t_any;
  logic [TAG_W-1:0] t_rd_tag [N_TBL];
  logic [TAG_W-1:0] t_pr_tag [N_TBL];

  logic d_inv, d_cln, i_inv, b_inv, b_clr_all;
  logic unused_bits;

  cms_decode u_decode (
    .crm_i (cmd_crm_i), .opc2_i (cmd_opc2_i), .user_i (cmd_user_i),
    .attr_o(attr), .bad_o(bad), .key_o(key)
  );

  // table 0 instruction, 1 data, 2 branch target
  for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
    assign t_fill[g] = fill_en_i && (fill_sel_i == 2'(g));
    cms_line_array #(.N_LINES(N_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_en_i   (t_fill[g]),
      .fill_idx_i  (fill_va_i[LINE_OFF +: IDX_W]),
      .fill_tag_i  (fill_va_i[ADDR_W-1 -: TAG_W]),
      .fill_dirty_i(fill_dirty_i && (g == 1)),
      .fill_lock_i (fill_lock_i),
      .op_idx_i    (op_idx),
      .inv_en_i    (t_inv[g]),
      .cln_en_i    (t_cln[g]),
      .clr_all_i   (t_clr[g]),
      .rd_valid_o  (t_rd_valid[g]),
      .rd_dirty_o  (t_rd_dirty[g]),
      .rd_tag_o    (t_rd_tag[g]),
      .pr_idx_i    (probe_va_i[LINE_OFF +: IDX_W]),
      .pr_valid_o  (t_pr_valid[g]),
      .pr_dirty_o  (t_pr_dirty[g]),
      .pr_lock_o   (t_pr_lock[g]),
      .pr_tag_o    (t_pr_tag[g]),
      .any_dirty_o (t_any[g])
    );
  end

  assign t_inv = {b_inv, d_inv, i_inv};
  assign t_cln = {1'b0, d_cln, 1'b0};
  assign t_clr = {b_clr_all, 2'b00};

  cms_ctrl #(.N_LINES(N_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .attr_i     (attr),
    .bad_i      (bad),
    .key_i      (key),
    .cmd_idx_i  (cmd_data_i[LINE_OFF +: IDX_W]),
    .cmd_tag_i  (cmd_data_i[ADDR_W-1 -: TAG_W]),
    .irq_i      (irq_i),
    .wb_ack_i   (wb_ack_i),
    .d_valid_i  (t_rd_valid[1]),
    .d_dirty_i  (t_rd_dirty[1]),
    .d_tag_i    (t_rd_tag[1]),
    .i_valid_i  (t_rd_valid[0]),
    .i_tag_i    (t_rd_tag[0]),
    .b_valid_i  (t_rd_valid[2]),
    .b_tag_i    (t_rd_tag[2]),
    .idx_o      (op_idx),
    .d_inv_o    (d_inv),
    .d_cln_o    (d_cln),
    .i_inv_o    (i_inv),
    .b_inv_o    (b_inv),
    .b_clr_all_o(b_clr_all),
    .busy_o     (busy_o),
    .trap_o     (trap_o),
    .intr_o     (intr_o),
    .wb_req_o   (wb_req_o),
    .wb_addr_o  (wb_addr_o)
  );

  always_comb begin
    probe_hit_o = 1'b0; probe_dirty_o = 1'b0; probe_lock_o = 1'b0;
    for (int t = 0; t < N_TBL; t++) begin
      if (probe_sel_i == 2'(t)) begin
        probe_hit_o   = t_pr_valid[t] && (t_pr_tag[t] == probe_va_i[ADDR_W-1 -: TAG_W]);
        probe_dirty_o = t_pr_dirty[t];
        probe_lock_o  = t_pr_lock[t];
      end
    end
  end

  assign dirty_o = t_any[1];
  // address offset bits, data word low bits and non-data dirty outputs are ignored
  assign unused_bits = ^{cmd_data_i[LINE_OFF-1:0], fill_va_i[LINE_OFF-1:0], probe_va_i[LINE_OFF-1:0],
                         t_rd_dirty[0], t_rd_dirty[2], t_any[0], t_any[2]};
endmodule

// File: rtl/cms_checker.sv
module cms_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_user_i,
  input logic        busy_o,
  input logic        trap_o,
  input logic        intr_o,
  input logic        wb_req_o,
  input logic        wb_ack_i,
  input logic [31:0] wb_addr_o
);
  p_trap_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o && cmd_user_i |=> trap_o && !busy_o);

  p_wb_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o));

  p_intr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> !busy_o);

  p_wb_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> busy_o);

  p_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o |=> busy_o || trap_o);
endmodule

bind cache_maint_seq cms_checker u_cms_checker (.*);

// File: tb/cache_maint_seq_bench.sv
module cache_maint_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_user = 0, irq = 0, wb_ack = 0;
  logic [3:0]  cmd_crm = 0;
  logic [2:0]  cmd_opc2 = 0;
  logic [31:0] cmd_data = 0;
  logic        fill_en = 0, fill_dirty = 0, fill_lock = 0;
  logic [1:0]  fill_sel = 0, probe_sel = 0;
  logic [31:0] fill_va = 0, probe_va = 0;
  logic        busy, trap, intr, dirty, wb_req, p_hit, p_dirty, p_lock;
  logic [31:0] wb_addr;

  int n_tests = 0, n_fail = 0;
  int wb_cnt = 0, wb_dly = 0;
  logic [31:0] wb_xor = 0, wb_last = 0;
  logic trap_seen;

  always #5 clk = ~clk;

  cache_maint_seq u_cache_maint_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_user_i(cmd_user),
    .cmd_crm_i(cmd_crm), .cmd_opc2_i(cmd_opc2), .cmd_data_i(cmd_data), .irq_i(irq),
    .busy_o(busy), .trap_o(trap), .intr_o(intr), .dirty_o(dirty),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_ack_i(wb_ack),
    .fill_en_i(fill_en), .fill_sel_i(fill_sel), .fill_va_i(fill_va),
    .fill_dirty_i(fill_dirty), .fill_lock_i(fill_lock),
    .probe_sel_i(probe_sel), .probe_va_i(probe_va),
    .probe_hit_o(p_hit), .probe_dirty_o(p_dirty), .probe_lock_o(p_lock)
  );

  // writeback responder: acknowledges on the second negedge of a request
  always @(negedge clk) begin
    if (wb_ack) wb_ack <= 1'b0;
    else if (wb_req) begin
      if (wb_dly == 1) begin
        wb_ack <= 1'b1; wb_dly <= 0; wb_cnt <= wb_cnt + 1;
        wb_xor <= wb_xor ^ wb_addr; wb_last <= wb_addr;
      end else wb_dly <= wb_dly + 1;
    end
  end

  function automatic logic [31:0] mkva(input logic [23:0] tag, input int idx);
    return {tag, 3'(idx), 5'b0};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 1'b0; irq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic fill(input logic [1:0] sel, input logic [31:0] va, input logic d, input logic l);
    @(negedge clk);
    fill_sel = sel; fill_va = va; fill_dirty = d; fill_lock = l; fill_en = 1'b1;
    @(negedge clk); fill_en = 1'b0; #1;
  endtask

  task automatic probe(input logic [1:0] sel, input logic [31:0] va, output logic h, output logic d, output logic l);
    probe_sel = sel; probe_va = va; #1;
    h = p_hit; d = p_dirty; l = p_lock;
  endtask

  task automatic issue(input logic [3:0] crm, input logic [2:0] opc2, input logic [31:0] data, input logic user);
    @(negedge clk);
    cmd_crm = crm; cmd_opc2 = opc2; cmd_data = data; cmd_user = user; cmd_valid = 1'b1;
    @(negedge clk); #1;
    trap_seen = trap;
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [3:0] crm, input logic [2:0] opc2, input logic [31:0] data, input logic user);
    issue(crm, opc2, data, user);
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R12", "busy", busy, 0);
    chk("R12", "trap", trap, 0);
    chk("R12", "intr", intr, 0);
    chk("R12", "dirty", dirty, 0);
    chk("R12", "wb_req", wb_req, 0);
  endtask

  task automatic t_clean_all();
    logic h, d, l; int c0; logic [31:0] x0, ex;
    reset_dut();
    ex = 0;
    for (int i = 0; i < 8; i++) begin
      fill(1, mkva(24'h300 + 24'(i), i), (i % 2) == 0, i == 2);
      if ((i % 2) == 0) ex ^= mkva(24'h300 + 24'(i), i);
    end
    chk("R11", "dirty after fill", dirty, 1);
    c0 = wb_cnt; x0 = wb_xor;
    run_cmd(10, 0, 0, 0);
    chk("R1", "clean writeback count", wb_cnt - c0, 4);
    chk("R7", "clean writeback addr xor", wb_xor ^ x0, ex);
    chk("R11", "dirty after clean", dirty, 0);
    probe(1, mkva(24'h302, 2), h, d, l);
    chk("R5", "locked line cleaned stays valid", {h, d, l}, 3'b101);
  endtask

  task automatic t_clean_inv_all();
    logic h, d, l; int c0;
    reset_dut();
    for (int i = 0; i < 8; i++) fill(1, mkva(24'h500 + 24'(i), i), i < 3, 1'b1);
    c0 = wb_cnt;
    run_cmd(14, 0, 0, 0);
    chk("R1", "clean+inv writeback count", wb_cnt - c0, 3);
    probe(1, mkva(24'h501, 1), h, d, l);
    chk("R5", "locked dirty line invalidated", h, 0);
    probe(1, mkva(24'h507, 7), h, d, l);
    chk("R7", "clean line invalidated", h, 0);
  endtask

  task automatic t_inv_i_all();
    logic h, d, l;
    reset_dut();
    fill(0, mkva(24'h11, 1), 0, 1); fill(0, mkva(24'h12, 6), 0, 0);
    fill(2, mkva(24'h11, 1), 0, 0); fill(1, mkva(24'h40, 3), 1, 0);
    run_cmd(5, 0, 0, 0);
    probe(0, mkva(24'h11, 1), h, d, l);
    chk("R1", "I line 1 after I inv all", h, 0);
    probe(0, mkva(24'h12, 6), h, d, l);
    chk("R1", "I line 6 after I inv all", h, 0);
    probe(2, mkva(24'h11, 1), h, d, l);
    chk("R3", "BTC flushed by I inv all", h, 0);
    probe(1, mkva(24'h40, 3), h, d, l);
    chk("R1", "D untouched by I inv all", {h, d}, 2'b11);
  endtask

  task automatic t_inv_d_both();
    logic h, d, l; int c0;
    reset_dut();
    fill(1, mkva(24'h40, 3), 1, 0); fill(0, mkva(24'h41, 4), 0, 0);
    c0 = wb_cnt;
    run_cmd(6, 0, 0, 0);
    chk("R7", "no writeback on D invalidate", wb_cnt - c0, 0);
    chk("R11", "dirty after D invalidate", dirty, 0);
    probe(0, mkva(24'h41, 4), h, d, l);
    chk("R1", "I untouched by D inv all", h, 1);
    fill(1, mkva(24'h42, 5), 0, 0); fill(2, mkva(24'h43, 0), 0, 0);
    run_cmd(7, 0, 0, 0);
    probe(0, mkva(24'h41, 4), h, d, l);
    chk("R1", "I cleared by both", h, 0);
    probe(1, mkva(24'h42, 5), h, d, l);
    chk("R1", "D cleared by both", h, 0);
    probe(2, mkva(24'h43, 0), h, d, l);
    chk("R3", "BTC cleared by both", h, 0);
    fill(2, mkva(24'h44, 2), 0, 0); fill(0, mkva(24'h45, 2), 0, 0);
    run_cmd(5, 6, 0, 0);
    probe(2, mkva(24'h44, 2), h, d, l);
    chk("R3", "BTC cleared by BTC flush all", h, 0);
    probe(0, mkva(24'h45, 2), h, d, l);
    chk("R3", "I kept by BTC flush all", h, 1);
  endtask

  task automatic t_single();
    logic h, d, l; int c0;
    reset_dut();
    fill(0, mkva(24'h21, 2), 0, 1); fill(0, mkva(24'h22, 3), 0, 0);
    fill(2, mkva(24'h21, 2), 0, 0); fill(2, mkva(24'h22, 3), 0, 0);
    run_cmd(5, 1, mkva(24'h21, 2) | 32'h1f, 0);
    probe(0, mkva(24'h21, 2), h, d, l);
    chk("R2", "I line invalidated (low bits ignored)", h, 0);
    probe(0, mkva(24'h22, 3), h, d, l);
    chk("R2", "other I line kept", h, 1);
    probe(2, mkva(24'h21, 2), h, d, l);
    chk("R4", "BTC kept after I line inv", h, 1);
    run_cmd(5, 7, mkva(24'h21, 2), 0);
    probe(2, mkva(24'h21, 2), h, d, l);
    chk("R4", "BTC entry flushed", h, 0);
    probe(2, mkva(24'h22, 3), h, d, l);
    chk("R4", "other BTC entry kept", h, 1);
    fill(1, mkva(24'h60, 4), 1, 1); fill(1, mkva(24'h61, 5), 1, 0);
    c0 = wb_cnt;
    run_cmd(10, 1, mkva(24'h60, 4), 0);
    chk("R7", "single clean writeback count", wb_cnt - c0, 1);
    chk("R7", "single clean address", wb_last, mkva(24'h60, 4));
    probe(1, mkva(24'h60, 4), h, d, l);
    chk("R5", "locked line cleaned", {h, d, l}, 3'b101);
    chk("R11", "dirty still set by other line", dirty, 1);
    c0 = wb_cnt;
    run_cmd(14, 1, mkva(24'h99, 5), 0);
    chk("R2", "tag miss no writeback", wb_cnt - c0, 0);
    probe(1, mkva(24'h61, 5), h, d, l);
    chk("R2", "tag miss line kept", {h, d}, 2'b11);
    run_cmd(14, 1, mkva(24'h61, 5), 0);
    probe(1, mkva(24'h61, 5), h, d, l);
    chk("R7", "single clean+inv line gone", h, 0);
    chk("R11", "dirty cleared", dirty, 0);
    run_cmd(6, 1, mkva(24'h60, 4), 0);
    probe(1, mkva(24'h60, 4), h, d, l);
    chk("R2", "single D invalidate", h, 0);
  endtask

  task automatic t_trap();
    logic h, d, l; int c0;
    reset_dut();
    fill(1, mkva(24'h70, 1), 1, 0); fill(0, mkva(24'h71, 1), 0, 0);
    c0 = wb_cnt;
    issue(14, 0, 0, 1);
    chk("R6", "user mode trap", trap_seen, 1);
    chk("R6", "user mode busy", busy, 0);
    @(negedge clk); #1;
    chk("R6", "trap is one cycle", trap, 0);
    issue(5, 0, 0, 1);
    chk("R6", "user I inv trap", trap_seen, 1);
    issue(3, 2, 0, 0);
    chk("R6", "unlisted encoding trap", trap_seen, 1);
    repeat (4) @(negedge clk); #1;
    chk("R6", "no writeback after traps", wb_cnt - c0, 0);
    probe(1, mkva(24'h70, 1), h, d, l);
    chk("R6", "D line unchanged", {h, d}, 2'b11);
    probe(0, mkva(24'h71, 1), h, d, l);
    chk("R6", "I line unchanged", h, 1);
  endtask

  task automatic t_interrupt();
    logic h, d, l; int c0; logic [31:0] x0, ex;
    reset_dut();
    ex = 0;
    for (int i = 0; i < 8; i++) begin
      fill(1, mkva(24'h800 + 24'(i), i), 1, 0);
      ex ^= mkva(24'h800 + 24'(i), i);
    end
    c0 = wb_cnt; x0 = wb_xor;
    irq = 1'b1;
    run_cmd(14, 0, 0, 0);
    irq = 1'b0;
    chk("R8", "intr flag", intr, 1);
    chk("R8", "busy after interrupt", busy, 0);
    chk("R8", "one line done before stop", wb_cnt - c0, 1);
    chk("R11", "dirty remains", dirty, 1);
    probe(1, mkva(24'h800, 0), h, d, l);
    chk("R8", "line 0 processed", h, 0);
    probe(1, mkva(24'h801, 1), h, d, l);
    chk("R8", "line 1 untouched", {h, d}, 2'b11);
    run_cmd(14, 0, 0, 0);
    chk("R9", "intr cleared", intr, 0);
    chk("R9", "total writebacks", wb_cnt - c0, 8);
    chk("R9", "writeback address set", wb_xor ^ x0, ex);
    chk("R9", "dirty after resume", dirty, 0);
    probe(1, mkva(24'h807, 7), h, d, l);
    chk("R9", "last line invalid", h, 0);
  endtask

  task automatic t_busy_drop();
    logic h, d, l;
    reset_dut();
    fill(1, mkva(24'h90, 0), 1, 0); fill(1, mkva(24'h91, 6), 1, 0);
    issue(10, 0, 0, 0);
    chk("R10", "busy after accept", busy, 1);
    @(negedge clk);
    cmd_crm = 6; cmd_opc2 = 0; cmd_data = 0; cmd_user = 0; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; #1;
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    chk("R10", "busy low at end", busy, 0);
    probe(1, mkva(24'h90, 0), h, d, l);
    chk("R10", "dropped invalidate had no effect", {h, d}, 2'b10);
    probe(1, mkva(24'h91, 6), h, d, l);
    chk("R10", "dropped invalidate line 6", {h, d}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_clean_all();
    t_clean_inv_all();
    t_inv_i_all();
    t_inv_d_both();
    t_single();
    t_trap();
    t_interrupt();
    t_busy_drop();
    summary();
    $finish;
  end
endmodule